// File: doc/BRIEF.md
# CAN Bit-Level Stuffing and Bus Integration Stage

This stage sits between a bit-timing unit and the frame logic of a CAN controller. It does one step per bit, on a strobe that the bit-timing unit raises once at each sample point. The stage waits until the bus has been idle long enough before it accepts a start-of-frame bit. It strips stuff bits from the received stream and passes on only the data bits, each with a valid pulse. It inserts stuff bits into the transmitted stream. It checks each level it drives against the level sampled from the bus.

One tracker holds the length and the level of the current run of equal bus bits, and both the receive path and the transmit path use it. Between the first bit of a frame and the end of its checksum field, the frame logic holds `stuff_en` high. When a run reaches five bits inside that window, the next bus bit is a stuff bit. On receive that bit is checked and dropped. On transmit the stage drives it instead of taking a bit from the serializer. Stuff errors and bit errors end the frame and start a new integration period. Losing arbitration only stops the stage from driving the bus. Two free-running counters count the bus bits seen in frames and the stuff bits removed.

The controller has three states:
- `ST_INTEG`: the stage counts recessive samples.
  - INTEG→IDLE: after 11 consecutive recessive samples.
- `ST_IDLE`: the stage hunts for a start-of-frame bit.
  - IDLE→FRAME: on a dominant sample.
  - IDLE→INTEG: on a bit error while sending a start-of-frame bit.
- `ST_FRAME`: a frame is in progress.
  - FRAME→INTEG: on a stuff error or a bit error.
  - FRAME→IDLE: on `frame_end` from the frame logic.

Top module: `can_bit_link`

## Requirements
- R1: After reset the stage is in integration. `tx_out` is recessive (1), every pulse output is 0, both counters are 0, and `tx_ready` is 0 even with `tx_active` high.
- R2: A start of frame is accepted only after 11 consecutive recessive (1) samples. A dominant (0) sample before the eleventh restarts the count.
- R3: In the idle state a dominant sample raises `sof`, produces a valid data bit of 0, and begins a frame.
- R4: With stuffing enabled, the sample that follows five equal bits is removed. It produces no `rx_valid` and increments `stuffed_bits`.
- R5: If that stuff sample has the same level as the preceding run, `stuff_err` pulses and the stage returns to integration, so a following dominant sample gives no `sof`.
- R6: A stuff bit counts as the first bit of a new run, so four more bits at its level make the next sample a stuff bit.
- R7: While `stuff_en` is low, runs are not tracked, and six equal bits all pass as data.
- R8: On transmit, after five equal driven bits, `tx_ready` is low at the next strobe and `tx_out` takes the opposite level for one bit. The serializer resumes at the strobe after that.
- R9: A mismatch between `tx_out` and the sampled bus outside the arbitration window pulses `bit_err`, forces `tx_out` recessive and restarts integration.
- R10: Inside the arbitration window, sending recessive and reading dominant pulses `arb_lost` without `bit_err`. The stage then stops driving and keeps `tx_ready` low for the rest of the frame.
- R11: `bus_bits` counts every sample taken in a frame, including start of frame and stuff bits.
- R12: `frame_end` returns the stage to the idle state, so the next dominant sample is a start of frame without a new integration period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse at each sample point |
| rx_bit | input | 1 | Sampled bus level, valid with `bit_strobe` (1 = recessive) |
| stuff_en | input | 1 | High while the current bit lies in the stuffed part of the frame |
| arb_field | input | 1 | High while the current bit lies in the arbitration field |
| frame_end | input | 1 | Pulse from the frame logic that closes the frame |
| tx_active | input | 1 | The serializer has a frame to send |
| tx_bit | input | 1 | Next bit from the serializer |
| tx_ready | output | 1 | `tx_bit` is taken at this strobe |
| tx_out | output | 1 | Level driven toward the bus for the current bit |
| rx_valid | output | 1 | Pulse: `rx_data` holds a destuffed bit |
| rx_data | output | 1 | Destuffed received bit |
| sof | output | 1 | Pulse: start of frame detected |
| stuff_err | output | 1 | Pulse: stuff rule violated |
| bit_err | output | 1 | Pulse: driven level not seen on the bus |
| arb_lost | output | 1 | Pulse: arbitration lost |
| bus_bits | output | 16 | Count of samples taken in frames |
| stuffed_bits | output | 16 | Count of stuff bits removed |

## Verification
A wrong run length or run level in the tracker shows up at most six strobes later. It appears as a data bit that should have been dropped, a stuff bit that was kept, or a false `stuff_err`. In the same bit the transmit side shows it as a misplaced `tx_ready` low. A wrong integration count shows up as a `sof` that arrives early, or does not arrive, at the first dominant sample after the idle run. A monitor that compares the wrong level shows up as `bit_err` or `arb_lost` on the very strobe of the mismatch. The directed scenarios drive each of these conditions and check the pulses one clock after the strobe.

// File: rtl/can_bit_link_pkg.sv
package can_bit_link_pkg;
    typedef enum logic [1:0] {
        ST_INTEG = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FRAME = 2'd2
    } link_state_e;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/cbl_integrator.sv
module cbl_integrator #(
    parameter int INTEG_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  logic bit_in,
    output logic done
);
    localparam int INT_W = $clog2(INTEG_BITS + 1);

    logic [INT_W-1:0] cnt_q;

    assign done = en && step && bit_in && (cnt_q == INT_W'(INTEG_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (step) begin
            if (bit_in && !done) cnt_q <= cnt_q + INT_W'(1);
            else                 cnt_q <= '0;
        end
    end

    // R2
    integ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < INT_W'(INTEG_BITS));
endmodule

// File: rtl/cbl_run_tracker.sv
module cbl_run_tracker #(
    parameter int STUFF_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    input  logic start,
    input  logic stuff_bit,
    input  logic arm,
    input  logic bit_in,
    output logic due_q,
    output logic pol_q,
    output logic next_due,
    output logic next_pol
);
    localparam int RUN_W = $clog2(STUFF_LEN + 1);

    logic [RUN_W-1:0] run_q, run_n;
    logic             pol_n;

    always_comb begin
        run_n = run_q;
        pol_n = pol_q;
        if (clear) begin
            run_n = '0;
            pol_n = 1'b1;
        end else if (!step) begin
            run_n = run_q;
        end else if (start || stuff_bit) begin
            run_n = RUN_W'(1);
            pol_n = bit_in;
        end else if (arm) begin
            if (bit_in == pol_q && run_q != '0) run_n = run_q + RUN_W'(1);
            else                                run_n = RUN_W'(1);
            pol_n = bit_in;
        end else begin
            run_n = '0;
            pol_n = bit_in;
        end
    end

    assign next_due = step && !clear && !stuff_bit && arm &&
                      (run_n == RUN_W'(STUFF_LEN));
    assign next_pol = pol_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            pol_q <= 1'b1;
            due_q <= 1'b0;
        end else if (clear || step) begin
            run_q <= run_n;
            pol_q <= pol_n;
            due_q <= next_due;
        end
    end

    // R6
    run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(STUFF_LEN));

    // R4
    due_at_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        due_q |-> (run_q == RUN_W'(STUFF_LEN)));
endmodule

// File: rtl/cbl_monitor.sv
module cbl_monitor (
    input  logic active,
    input  logic driving,
    input  logic tx_lvl,
    input  logic bus_lvl,
    input  logic arb_field,
    input  logic stuff_bit,
    output logic mon_err,
    output logic mon_arb
);
    logic mismatch;

    always_comb begin
        mismatch = active && driving && (tx_lvl != bus_lvl);
        mon_arb  = mismatch && arb_field && tx_lvl && !stuff_bit;
        mon_err  = mismatch && !mon_arb;
    end
endmodule

// File: rtl/can_bit_link.sv
module can_bit_link
    import can_bit_link_pkg::*;
#(
    parameter int INTEG_BITS = 11,
    parameter int STUFF_LEN  = 5,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             rx_bit,
    input  logic             stuff_en,
    input  logic             arb_field,
    input  logic             frame_end,
    input  logic             tx_active,
    input  logic             tx_bit,
    output logic             tx_ready,
    output logic             tx_out,
    output logic             rx_valid,
    output logic             rx_data,
    output logic             sof,
    output logic             stuff_err,
    output logic             bit_err,
    output logic             arb_lost,
    output logic [CNT_W-1:0] bus_bits,
    output logic [CNT_W-1:0] stuffed_bits
);
    link_state_e state_q, state_n;

    logic integ_done;
    logic due_q, pol_q, next_due, next_pol;
    logic mon_err, mon_arb;
    logic drv_q, lost_q;
    logic stuff_bit, stuff_bad, err, sof_evt, keep_tx;

    cbl_integrator #(.INTEG_BITS(INTEG_BITS)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q == ST_INTEG),
        .step   (bit_strobe),
        .bit_in (rx_bit),
        .done   (integ_done)
    );

    cbl_monitor u_mon (
        .active    (bit_strobe && state_q != ST_INTEG),
        .driving   (drv_q),
        .tx_lvl    (tx_out),
        .bus_lvl   (rx_bit),
        .arb_field (arb_field),
        .stuff_bit (stuff_bit),
        .mon_err   (mon_err),
        .mon_arb   (mon_arb)
    );

    always_comb begin
        stuff_bit = (state_q == ST_FRAME) && due_q;
        stuff_bad = bit_strobe && stuff_bit && (rx_bit == pol_q);
        err       = stuff_bad || mon_err;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_INTEG: if (integ_done) state_n = ST_IDLE;
            ST_IDLE: begin
                if (bit_strobe && err)                    state_n = ST_INTEG;
                else if (bit_strobe && rx_bit == LVL_DOM) state_n = ST_FRAME;
            end
            ST_FRAME: begin
                if (bit_strobe && err) state_n = ST_INTEG;
                else if (frame_end)    state_n = ST_IDLE;
            end
            default: state_n = ST_INTEG;
        endcase
    end

    assign sof_evt = bit_strobe && (state_q == ST_IDLE) && (state_n == ST_FRAME);

    cbl_run_tracker #(.STUFF_LEN(STUFF_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (bit_strobe),
        .clear     (state_n != ST_FRAME),
        .start     (state_q == ST_IDLE),
        .stuff_bit (stuff_bit),
        .arm       (stuff_en),
        .bit_in    (rx_bit),
        .due_q     (due_q),
        .pol_q     (pol_q),
        .next_due  (next_due),
        .next_pol  (next_pol)
    );

    always_comb begin
        keep_tx  = tx_active && !lost_q && !mon_arb && !err && (state_q != ST_INTEG);
        tx_ready = keep_tx && !next_due;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INTEG;
        else        state_q <= state_n;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_out       <= LVL_REC;
            drv_q        <= 1'b0;
            lost_q       <= 1'b0;
            rx_valid     <= 1'b0;
            rx_data      <= LVL_REC;
            sof          <= 1'b0;
            stuff_err    <= 1'b0;
            bit_err      <= 1'b0;
            arb_lost     <= 1'b0;
            bus_bits     <= '0;
            stuffed_bits <= '0;
        end else begin
            rx_valid  <= 1'b0;
            sof       <= 1'b0;
            stuff_err <= 1'b0;
            bit_err   <= 1'b0;
            arb_lost  <= 1'b0;
            if (bit_strobe) begin
                if (keep_tx) begin
                    tx_out <= next_due ? ~next_pol : tx_bit;
                    drv_q  <= 1'b1;
                end else begin
                    tx_out <= LVL_REC;
                    drv_q  <= 1'b0;
                end
                stuff_err <= stuff_bad;
                bit_err   <= mon_err;
                arb_lost  <= mon_arb;
                if (sof_evt) begin
                    sof      <= 1'b1;
                    rx_valid <= 1'b1;
                    rx_data  <= rx_bit;
                end else if (state_q == ST_FRAME && !stuff_bit && !err) begin
                    rx_valid <= 1'b1;
                    rx_data  <= rx_bit;
                end
                if (sof_evt || state_q == ST_FRAME) bus_bits <= bus_bits + CNT_W'(1);
                if (stuff_bit && !err) stuffed_bits <= stuffed_bits + CNT_W'(1);
            end else if (frame_end) begin
                tx_out <= LVL_REC;
                drv_q  <= 1'b0;
            end
            if (bit_strobe && mon_arb)    lost_q <= 1'b1;
            else if (state_n != ST_FRAME) lost_q <= 1'b0;
        end
    end

    // R3
    sof_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> ($past(state_q) == ST_IDLE && state_q == ST_FRAME));

    // R4
    removed_not_passed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuffed_bits != $past(stuffed_bits)) |-> !rx_valid);

    // R5
    stuff_err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> (state_q == ST_INTEG));

    // R9
    bit_err_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> (state_q == ST_INTEG && tx_out == LVL_REC));

    // R10
    arb_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!bit_err && tx_out == LVL_REC && !tx_ready));
endmodule

// File: tb/tb_can_bit_link.sv
module tb_can_bit_link;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0, rx_bit = 1'b1, stuff_en = 1'b0, arb_field = 1'b0;
    logic        frame_end = 1'b0, tx_active = 1'b0, tx_bit = 1'b1;
    logic        tx_ready, tx_out, rx_valid, rx_data, sof, stuff_err, bit_err, arb_lost;
    logic [15:0] bus_bits, stuffed_bits;

    int n_chk = 0, n_fail = 0, vcnt = 0;
    logic c_valid, c_data, c_sof, c_serr, c_berr, c_arb, c_ready;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_bit_link dut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .stuff_en(stuff_en), .arb_field(arb_field), .frame_end(frame_end),
        .tx_active(tx_active), .tx_bit(tx_bit), .tx_ready(tx_ready), .tx_out(tx_out),
        .rx_valid(rx_valid), .rx_data(rx_data), .sof(sof), .stuff_err(stuff_err),
        .bit_err(bit_err), .arb_lost(arb_lost), .bus_bits(bus_bits),
        .stuffed_bits(stuffed_bits)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one bit period: bus = driven level AND other node's level
    task automatic do_bit(input logic other);
        @(negedge clk);
        rx_bit = tx_out & other;
        bit_strobe = 1'b1;
        #1 c_ready = tx_ready;
        @(negedge clk);
        bit_strobe = 1'b0;
        c_valid = rx_valid; c_data = rx_data; c_sof = sof;
        c_serr = stuff_err; c_berr = bit_err; c_arb = arb_lost;
        if (c_valid) vcnt++;
        @(negedge clk);
    endtask

    task automatic integrate();
        for (int i = 0; i < 11; i++) do_bit(1'b1);
    endtask

    task automatic t_reset();
        tx_active = 1'b1;
        #1;
        chk(tx_out == 1'b1, "R1 tx_out", tx_out, 1);
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
        chk({rx_valid, sof, stuff_err, bit_err, arb_lost} == 5'b0, "R1 pulses",
            {rx_valid, sof, stuff_err, bit_err, arb_lost}, 0);
        chk(bus_bits == 0 && stuffed_bits == 0, "R1 counters", bus_bits + stuffed_bits, 0);
        tx_active = 1'b0;
    endtask

    task automatic t_integration();
        for (int i = 0; i < 10; i++) do_bit(1'b1);
        do_bit(1'b0);
        chk(c_sof == 1'b0, "R2 early sof", c_sof, 0);
        integrate();
        stuff_en = 1'b1;
        do_bit(1'b0);
        chk(c_sof == 1'b1, "R2 sof after 11", c_sof, 1);
        chk(c_valid && c_data == 1'b0, "R3 sof data", {c_valid, c_data}, 2);
    endtask

    task automatic t_destuff();
        int b0, s0;
        b0 = bus_bits; s0 = stuffed_bits; vcnt = 0;
        for (int i = 0; i < 4; i++) do_bit(1'b0);
        do_bit(1'b1);
        chk(c_valid == 1'b0, "R4 stuff removed", c_valid, 0);
        for (int i = 0; i < 4; i++) do_bit(1'b1);
        chk(c_valid && c_data == 1'b1, "R6 data bit", {c_valid, c_data}, 3);
        do_bit(1'b0);
        chk(c_valid == 1'b0 && c_serr == 1'b0, "R6 stuff after stuff", {c_valid, c_serr}, 0);
        chk(vcnt == 8, "R4 valid count", vcnt, 8);
        chk(int'(stuffed_bits) - s0 == 2, "R4 stuffed count", int'(stuffed_bits) - s0, 2);
        chk(int'(bus_bits) - b0 == 10, "R11 bus count", int'(bus_bits) - b0, 10);
    endtask

    task automatic t_stuff_error();
        for (int i = 0; i < 4; i++) do_bit(1'b0);
        do_bit(1'b0);
        chk(c_serr == 1'b1, "R5 stuff_err", c_serr, 1);
        do_bit(1'b0);
        chk(c_sof == 1'b0, "R5 restart integration", c_sof, 0);
    endtask

    task automatic t_no_stuff_region();
        int s0;
        integrate();
        stuff_en = 1'b1;
        do_bit(1'b0);
        chk(c_sof == 1'b1, "R3 sof", c_sof, 1);
        stuff_en = 1'b0; vcnt = 0; s0 = stuffed_bits;
        for (int i = 0; i < 6; i++) do_bit(1'b0);
        chk(vcnt == 6, "R7 all passed", vcnt, 6);
        chk(int'(stuffed_bits) == s0 && !c_serr, "R7 none removed", int'(stuffed_bits) - s0, 0);
    endtask

    task automatic t_frame_end();
        @(negedge clk) frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
        do_bit(1'b0);
        chk(c_sof == 1'b1, "R12 sof without integration", c_sof, 1);
        @(negedge clk) frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
    endtask

    task automatic t_tx_stuff();
        logic [5:0] q = 6'b100000;
        int idx = 0, errs = 0;
        stuff_en = 1'b1; tx_active = 1'b1;
        for (int s = 1; s <= 7; s++) begin
            tx_bit = q[idx];
            do_bit(1'b1);
            if (c_ready) idx++;
            if (c_berr || c_serr) errs++;
            if (s == 6) begin
                chk(c_ready == 1'b0, "R8 ready low on stuff", c_ready, 0);
                chk(tx_out == 1'b1, "R8 stuff level", tx_out, 1);
            end
            if (s == 7) chk(c_ready == 1'b1, "R8 ready resumes", c_ready, 1);
        end
        chk(idx == 6, "R8 bits taken", idx, 6);
        chk(errs == 0, "R8 no errors", errs, 0);
    endtask

    task automatic t_bit_error();
        tx_active = 1'b0;
        do_bit(1'b0);
        chk(c_berr == 1'b1 && c_arb == 1'b0, "R9 bit_err", {c_berr, c_arb}, 2);
        chk(tx_out == 1'b1, "R9 recessive", tx_out, 1);
        do_bit(1'b0);
        chk(c_sof == 1'b0, "R9 integration restart", c_sof, 0);
    endtask

    task automatic t_arb_loss();
        integrate();
        tx_active = 1'b1; tx_bit = 1'b0;
        do_bit(1'b1);
        tx_bit = 1'b1;
        do_bit(1'b1);
        chk(c_sof == 1'b1, "R3 own sof", c_sof, 1);
        arb_field = 1'b1;
        do_bit(1'b0);
        chk(c_arb == 1'b1 && c_berr == 1'b0, "R10 arb_lost", {c_arb, c_berr}, 2);
        chk(tx_out == 1'b1, "R10 stop driving", tx_out, 1);
        do_bit(1'b0);
        chk(c_ready == 1'b0 && c_berr == 1'b0, "R10 silent after loss", {c_ready, c_berr}, 0);
        arb_field = 1'b0; tx_active = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integration();
        t_destuff();
        t_stuff_error();
        t_no_stuff_region();
        t_frame_end();
        t_tx_stuff();
        t_bit_error();
        t_arb_loss();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule